// File: doc/BRIEF.md
# Card Command Load Arbiter

This block sits at the front of the command path in an SD/MMC host controller and decides when a new request is taken in. It can take a request from three places. The first is a host register write that sets a start bit. The second is a stop-command request that the data path raises when a transfer ends. The third is a host request to answer a pending MMC interrupt. When it accepts a request, it latches either a full command (index, argument, timeout) for the serial engine, or only the card clock settings (enable, divider, source).

A host request can be made to wait for the previous data transfer. The wait applies only to transfers of predefined length. An open-ended transfer, marked by a byte count of zero, never holds a request back. While the command engine reports busy, nothing is loaded. When requests coincide, a fixed priority picks one. Each accepted host request returns a one-cycle acknowledge, and the start bit clears at that moment.

Top module: `cmd_load_arb`

## Requirements
- R1: A `host_start_set` pulse sets `start_pending` at the next rising edge. On the edge where the host request is loaded, `host_ack` goes high for exactly one cycle and `start_pending` goes low at that same edge.
- R2: A host request loaded with `host_clk_only`=1 latches `clk_en`, `clk_div` and `clk_src` from the host inputs and pulses `clk_upd` for one cycle. It raises no `cmd_valid`, and `cmd_idx`, `cmd_arg` and `cmd_tmo` keep their previous values.
- R3: A host request loaded with `host_clk_only`=0 latches `cmd_idx`, `cmd_arg` and `cmd_tmo` from the host inputs. It pulses `cmd_valid` for one cycle with `cmd_src`=0 (host).
- R4: With `host_wait_prev`=1, a host request loads at the first edge after `start_pending` is set when `dp_active`=0, or when `dp_active`=1 with `dp_byte_cnt`=0.
- R5: With `host_wait_prev`=1, `dp_active`=1 and a nonzero `dp_byte_cnt`, the host request stays pending with no output. It loads at the first edge after `dp_active` falls.
- R6: With `host_wait_prev`=0, a host request loads without regard to `dp_active` or `dp_byte_cnt`.
- R7: A `dp_done` pulse queues an automatic stop command. The command issues with `cmd_idx`=STOP_IDX (default 12), `cmd_arg`=0, `cmd_tmo`=`host_tmo` and `cmd_src`=1, and without `host_ack`.
- R8: An `irq_send_req` pulse while `irq_wait`=1 queues an interrupt response. It issues with `cmd_idx`=IRQ_IDX (default 40), `cmd_arg`=0 (card address 0x0000 in bits 31:16) and `cmd_src`=2, and without `host_ack`. The same pulse while `irq_wait`=0 is ignored.
- R9: When several requests are pending, they load one per edge in this order: stop first, then interrupt response, then host.
- R10: While `eng_busy`=1, no request is loaded, and pending requests are kept.
- R11: After reset, `start_pending`, `host_ack`, `cmd_valid`, `clk_upd` and all latched fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_start_set | input | 1 | Host write pulse that sets the start bit |
| host_clk_only | input | 1 | Request updates only the clock settings |
| host_wait_prev | input | 1 | Wait for a predefined-length transfer to end |
| host_cmd_idx | input | IDX_W | Host command index |
| host_arg | input | ARG_W | Host command argument |
| host_tmo | input | TMO_W | Host response timeout |
| host_clk_en | input | CEN_W | Host clock enable value |
| host_clk_div | input | DIV_W | Host clock divider value |
| host_clk_src | input | CSRC_W | Host clock source value |
| dp_active | input | 1 | Data transfer in progress |
| dp_byte_cnt | input | BCNT_W | Transfer byte count, 0 means open-ended |
| dp_done | input | 1 | Pulse at end of data transfer |
| irq_wait | input | 1 | Engine is waiting for an MMC interrupt |
| irq_send_req | input | 1 | Host pulse to send the interrupt response |
| eng_busy | input | 1 | Command engine busy |
| start_pending | output | 1 | Start bit as seen by the host |
| host_ack | output | 1 | One-cycle acknowledge of a host load |
| cmd_valid | output | 1 | One-cycle pulse: command ready for the engine |
| cmd_src | output | 2 | Source of command: 0 host, 1 stop, 2 interrupt |
| cmd_idx | output | IDX_W | Latched command index |
| cmd_arg | output | ARG_W | Latched argument |
| cmd_tmo | output | TMO_W | Latched timeout |
| clk_upd | output | 1 | One-cycle pulse: clock settings updated |
| clk_en | output | CEN_W | Latched clock enable |
| clk_div | output | DIV_W | Latched clock divider |
| clk_src | output | CSRC_W | Latched clock source |

## Verification
A host command goes through four data-path situations: idle, open-ended active, predefined-length active with waiting enabled, and predefined-length active with waiting disabled. Together these separate the byte-count-zero exemption, the deferral, and the effect of the wait flag. A clock-only request is followed by a check that the command fields are untouched, which tells the two load kinds apart. An interrupt request is tried both outside and inside the waiting window to show that it is gated. Finally, all three sources are raised together under engine busy and then released, which shows both that busy blocks loads and that the grants come out in priority order.

// File: rtl/cmd_load_pkg.sv
package cmd_load_pkg;

    typedef enum logic [1:0] {
        SRC_HOST = 2'd0,
        SRC_STOP = 2'd1,
        SRC_IRQ  = 2'd2
    } src_e;

    typedef struct packed {
        logic valid;
        src_e src;
    } grant_t;

    typedef struct packed {
        logic stop;
        logic irq;
        logic host;
    } pend_t;

    function automatic logic host_may_load(input logic wait_prev,
                                           input logic dp_active,
                                           input logic bcnt_zero);
        return !wait_prev || !dp_active || bcnt_zero;
    endfunction

endpackage

// File: rtl/cmd_load_pending.sv
module cmd_load_pending
    import cmd_load_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   host_start_set,
    input  logic   dp_done,
    input  logic   irq_wait,
    input  logic   irq_send_req,
    input  grant_t gnt,
    output pend_t  pend
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            if (dp_done)
                pend.stop <= 1'b1;
            else if (gnt.valid && gnt.src == SRC_STOP)
                pend.stop <= 1'b0;

            if (!irq_wait)
                pend.irq <= 1'b0;
            else if (irq_send_req)
                pend.irq <= 1'b1;
            else if (gnt.valid && gnt.src == SRC_IRQ)
                pend.irq <= 1'b0;

            if (host_start_set)
                pend.host <= 1'b1;
            else if (gnt.valid && gnt.src == SRC_HOST)
                pend.host <= 1'b0;
        end
    end

    AST_IRQ_NEEDS_WAIT: assert property (@(posedge clk) disable iff (rst)
        !irq_wait |=> !pend.irq); // R8

endmodule

// File: rtl/cmd_load_select.sv
module cmd_load_select
    import cmd_load_pkg::*;
#(
    parameter int BCNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  pend_t             pend,
    input  logic              eng_busy,
    input  logic              wait_prev,
    input  logic              dp_active,
    input  logic [BCNT_W-1:0] dp_byte_cnt,
    output grant_t            gnt
);

    logic bcnt_zero;
    logic host_ok;

    assign bcnt_zero = (dp_byte_cnt == '0);
    assign host_ok   = host_may_load(wait_prev, dp_active, bcnt_zero);

    always_comb begin
        gnt = '{valid: 1'b0, src: SRC_HOST};
        if (!eng_busy) begin
            if (pend.stop)
                gnt = '{valid: 1'b1, src: SRC_STOP};
            else if (pend.irq)
                gnt = '{valid: 1'b1, src: SRC_IRQ};
            else if (pend.host && host_ok)
                gnt = '{valid: 1'b1, src: SRC_HOST};
        end
    end

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        eng_busy |-> !gnt.valid); // R10
    AST_DEFER_PREDEF: assert property (@(posedge clk) disable iff (rst)
        (wait_prev && dp_active && dp_byte_cnt != '0) |->
        !(gnt.valid && gnt.src == SRC_HOST)); // R5
    AST_STOP_FIRST: assert property (@(posedge clk) disable iff (rst)
        (pend.stop && !eng_busy) |-> (gnt.valid && gnt.src == SRC_STOP)); // R9

endmodule

// File: rtl/cmd_load_regs.sv
module cmd_load_regs
    import cmd_load_pkg::*;
#(
    parameter int          IDX_W    = 6,
    parameter int          ARG_W    = 32,
    parameter int          TMO_W    = 32,
    parameter int          CEN_W    = 4,
    parameter int          DIV_W    = 8,
    parameter int          CSRC_W   = 2,
    parameter logic [IDX_W-1:0] STOP_IDX = 12,
    parameter logic [IDX_W-1:0] IRQ_IDX  = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  grant_t            gnt,
    input  logic              host_clk_only,
    input  logic [IDX_W-1:0]  host_cmd_idx,
    input  logic [ARG_W-1:0]  host_arg,
    input  logic [TMO_W-1:0]  host_tmo,
    input  logic [CEN_W-1:0]  host_clk_en,
    input  logic [DIV_W-1:0]  host_clk_div,
    input  logic [CSRC_W-1:0] host_clk_src,
    output logic              host_ack,
    output logic              cmd_valid,
    output src_e              cmd_src,
    output logic [IDX_W-1:0]  cmd_idx,
    output logic [ARG_W-1:0]  cmd_arg,
    output logic [TMO_W-1:0]  cmd_tmo,
    output logic              clk_upd,
    output logic [CEN_W-1:0]  clk_en,
    output logic [DIV_W-1:0]  clk_div,
    output logic [CSRC_W-1:0] clk_src
);

    always_ff @(posedge clk) begin
        if (rst) begin
            host_ack  <= 1'b0;
            cmd_valid <= 1'b0;
            clk_upd   <= 1'b0;
            cmd_src   <= SRC_HOST;
            cmd_idx   <= '0;
            cmd_arg   <= '0;
            cmd_tmo   <= '0;
            clk_en    <= '0;
            clk_div   <= '0;
            clk_src   <= '0;
        end else begin
            host_ack  <= 1'b0;
            cmd_valid <= 1'b0;
            clk_upd   <= 1'b0;
            if (gnt.valid) begin
                unique case (gnt.src)
                    SRC_STOP: begin
                        cmd_valid <= 1'b1;
                        cmd_src   <= SRC_STOP;
                        cmd_idx   <= STOP_IDX;
                        cmd_arg   <= '0;
                        cmd_tmo   <= host_tmo;
                    end
                    SRC_IRQ: begin
                        cmd_valid <= 1'b1;
                        cmd_src   <= SRC_IRQ;
                        cmd_idx   <= IRQ_IDX;
                        cmd_arg   <= '0;
                        cmd_tmo   <= host_tmo;
                    end
                    default: begin
                        host_ack <= 1'b1;
                        if (host_clk_only) begin
                            clk_upd <= 1'b1;
                            clk_en  <= host_clk_en;
                            clk_div <= host_clk_div;
                            clk_src <= host_clk_src;
                        end else begin
                            cmd_valid <= 1'b1;
                            cmd_src   <= SRC_HOST;
                            cmd_idx   <= host_cmd_idx;
                            cmd_arg   <= host_arg;
                            cmd_tmo   <= host_tmo;
                        end
                    end
                endcase
            end
        end
    end

    AST_CLK_ONLY_KEEPS_CMD: assert property (@(posedge clk) disable iff (rst)
        clk_upd |-> ($stable(cmd_idx) && $stable(cmd_arg) && !cmd_valid)); // R2
    AST_AUTO_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_src != SRC_HOST) |-> !host_ack); // R7

endmodule

// File: rtl/cmd_load_arb.sv
module cmd_load_arb
    import cmd_load_pkg::*;
#(
    parameter int          IDX_W    = 6,
    parameter int          ARG_W    = 32,
    parameter int          TMO_W    = 32,
    parameter int          CEN_W    = 4,
    parameter int          DIV_W    = 8,
    parameter int          CSRC_W   = 2,
    parameter int          BCNT_W   = 16,
    parameter logic [IDX_W-1:0] STOP_IDX = 12,
    parameter logic [IDX_W-1:0] IRQ_IDX  = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_start_set,
    input  logic              host_clk_only,
    input  logic              host_wait_prev,
    input  logic [IDX_W-1:0]  host_cmd_idx,
    input  logic [ARG_W-1:0]  host_arg,
    input  logic [TMO_W-1:0]  host_tmo,
    input  logic [CEN_W-1:0]  host_clk_en,
    input  logic [DIV_W-1:0]  host_clk_div,
    input  logic [CSRC_W-1:0] host_clk_src,
    input  logic              dp_active,
    input  logic [BCNT_W-1:0] dp_byte_cnt,
    input  logic              dp_done,
    input  logic              irq_wait,
    input  logic              irq_send_req,
    input  logic              eng_busy,
    output logic              start_pending,
    output logic              host_ack,
    output logic              cmd_valid,
    output logic [1:0]        cmd_src,
    output logic [IDX_W-1:0]  cmd_idx,
    output logic [ARG_W-1:0]  cmd_arg,
    output logic [TMO_W-1:0]  cmd_tmo,
    output logic              clk_upd,
    output logic [CEN_W-1:0]  clk_en,
    output logic [DIV_W-1:0]  clk_div,
    output logic [CSRC_W-1:0] clk_src
);

    pend_t  pend;
    grant_t gnt;
    src_e   src_q;

    cmd_load_pending u_pend (
        .clk            (clk),
        .rst            (rst),
        .host_start_set (host_start_set),
        .dp_done        (dp_done),
        .irq_wait       (irq_wait),
        .irq_send_req   (irq_send_req),
        .gnt            (gnt),
        .pend           (pend)
    );

    cmd_load_select #(.BCNT_W(BCNT_W)) u_sel (
        .clk         (clk),
        .rst         (rst),
        .pend        (pend),
        .eng_busy    (eng_busy),
        .wait_prev   (host_wait_prev),
        .dp_active   (dp_active),
        .dp_byte_cnt (dp_byte_cnt),
        .gnt         (gnt)
    );

    cmd_load_regs #(
        .IDX_W(IDX_W), .ARG_W(ARG_W), .TMO_W(TMO_W), .CEN_W(CEN_W),
        .DIV_W(DIV_W), .CSRC_W(CSRC_W), .STOP_IDX(STOP_IDX), .IRQ_IDX(IRQ_IDX)
    ) u_regs (
        .clk           (clk),
        .rst           (rst),
        .gnt           (gnt),
        .host_clk_only (host_clk_only),
        .host_cmd_idx  (host_cmd_idx),
        .host_arg      (host_arg),
        .host_tmo      (host_tmo),
        .host_clk_en   (host_clk_en),
        .host_clk_div  (host_clk_div),
        .host_clk_src  (host_clk_src),
        .host_ack      (host_ack),
        .cmd_valid     (cmd_valid),
        .cmd_src       (src_q),
        .cmd_idx       (cmd_idx),
        .cmd_arg       (cmd_arg),
        .cmd_tmo       (cmd_tmo),
        .clk_upd       (clk_upd),
        .clk_en        (clk_en),
        .clk_div       (clk_div),
        .clk_src       (clk_src)
    );

    assign cmd_src       = src_q;
    assign start_pending = pend.host;

    AST_ACK_CLEARS_START: assert property (@(posedge clk) disable iff (rst)
        host_ack |-> (!start_pending || $past(host_start_set))); // R1
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        host_ack |=> !host_ack); // R1
    AST_LOAD_KINDS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && clk_upd)); // R2

endmodule

// File: tb/cmd_load_arb_tb_top.sv
module cmd_load_arb_tb_top;

    typedef struct {
        bit          is_clk;
        bit          ack;
        logic [1:0]  src;
        logic [5:0]  idx;
        logic [31:0] arg;
        logic [31:0] tmo;
        logic [3:0]  cen;
        logic [7:0]  div;
        logic [1:0]  csrc;
        string       tag;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_start_set = 0, host_clk_only = 0, host_wait_prev = 0;
    logic [5:0]  host_cmd_idx = 0;
    logic [31:0] host_arg = 0, host_tmo = 0;
    logic [3:0]  host_clk_en = 0;
    logic [7:0]  host_clk_div = 0;
    logic [1:0]  host_clk_src = 0;
    logic dp_active = 0, dp_done = 0, irq_wait = 0, irq_send_req = 0, eng_busy = 0;
    logic [15:0] dp_byte_cnt = 0;
    logic start_pending, host_ack, cmd_valid, clk_upd;
    logic [1:0]  cmd_src;
    logic [5:0]  cmd_idx;
    logic [31:0] cmd_arg, cmd_tmo;
    logic [3:0]  clk_en;
    logic [7:0]  clk_div;
    logic [1:0]  clk_src;

    int checks = 0, errors = 0, observed = 0;
    bit done = 0;
    item_t expq[$];

    always #5 clk = ~clk;

    cmd_load_arb dut_i (
        .clk(clk), .rst(rst), .host_start_set(host_start_set),
        .host_clk_only(host_clk_only), .host_wait_prev(host_wait_prev),
        .host_cmd_idx(host_cmd_idx), .host_arg(host_arg), .host_tmo(host_tmo),
        .host_clk_en(host_clk_en), .host_clk_div(host_clk_div),
        .host_clk_src(host_clk_src), .dp_active(dp_active),
        .dp_byte_cnt(dp_byte_cnt), .dp_done(dp_done), .irq_wait(irq_wait),
        .irq_send_req(irq_send_req), .eng_busy(eng_busy),
        .start_pending(start_pending), .host_ack(host_ack),
        .cmd_valid(cmd_valid), .cmd_src(cmd_src), .cmd_idx(cmd_idx),
        .cmd_arg(cmd_arg), .cmd_tmo(cmd_tmo), .clk_upd(clk_upd),
        .clk_en(clk_en), .clk_div(clk_div), .clk_src(clk_src)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic exp_cmd(input logic [1:0] src, input logic [5:0] idx,
                           input logic [31:0] arg, input logic [31:0] tmo,
                           input bit ack, input string tag);
        item_t it;
        it.is_clk = 0; it.ack = ack; it.src = src; it.idx = idx;
        it.arg = arg; it.tmo = tmo; it.cen = 0; it.div = 0; it.csrc = 0;
        it.tag = tag;
        expq.push_back(it);
    endtask

    task automatic exp_clk(input logic [3:0] cen, input logic [7:0] div,
                           input logic [1:0] csrc, input string tag);
        item_t it;
        it.is_clk = 1; it.ack = 1; it.src = 0; it.idx = 0; it.arg = 0;
        it.tmo = 0; it.cen = cen; it.div = div; it.csrc = csrc; it.tag = tag;
        expq.push_back(it);
    endtask

    // Monitor: pops expected items as the design produces loads
    always @(negedge clk) begin
        if (!rst && (cmd_valid || clk_upd || host_ack)) begin
            observed++;
            if (expq.size() == 0) begin
                check(0, "unexpected load", {cmd_valid, clk_upd, host_ack}, 0);
            end else begin
                item_t e;
                e = expq.pop_front();
                if (e.is_clk)
                    check(clk_upd && !cmd_valid && host_ack && clk_en == e.cen &&
                          clk_div == e.div && clk_src == e.csrc, e.tag,
                          {cmd_valid, clk_upd, host_ack, clk_en, clk_div, clk_src},
                          {1'b0, 1'b1, 1'b1, e.cen, e.div, e.csrc});
                else
                    check(cmd_valid && !clk_upd && host_ack == e.ack &&
                          cmd_src == e.src && cmd_idx == e.idx &&
                          cmd_arg == e.arg && cmd_tmo == e.tmo, e.tag,
                          {host_ack, cmd_src, cmd_idx, cmd_arg, cmd_tmo[15:0]},
                          {e.ack, e.src, e.idx, e.arg, e.tmo[15:0]});
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        host_start_set = 1; tick(1); host_start_set = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seen;
        tick(3);
        // R11 reset state, sampled during reset
        check(!start_pending && !host_ack && !cmd_valid && !clk_upd &&
              cmd_idx == 0 && cmd_arg == 0 && clk_div == 0, "R11 reset state",
              {start_pending, host_ack, cmd_valid, clk_upd, cmd_idx, clk_div}, 0);
        rst = 0;
        tick(2);

        // R3 / R6: host command, wait flag clear, predefined transfer active
        host_cmd_idx = 6'd17; host_arg = 32'hA5A5_0001; host_tmo = 32'h40;
        dp_active = 1; dp_byte_cnt = 16'd512; host_wait_prev = 0;
        exp_cmd(2'd0, 6'd17, 32'hA5A5_0001, 32'h40, 1, "R3 R6 host command");
        pulse_start();
        check(start_pending, "R1 start pending set", start_pending, 1);
        tick(1);
        check(!start_pending, "R1 start cleared with ack", start_pending, 0);
        dp_active = 0;
        tick(2);

        // R2: clock-only update, command fields untouched
        host_clk_only = 1; host_clk_en = 4'h9; host_clk_div = 8'h3C; host_clk_src = 2'd2;
        host_cmd_idx = 6'd55; host_arg = 32'hDEAD_BEEF;
        exp_clk(4'h9, 8'h3C, 2'd2, "R2 clock-only update");
        pulse_start();
        tick(2);
        check(cmd_idx == 6'd17 && cmd_arg == 32'hA5A5_0001, "R2 cmd fields kept",
              {cmd_idx, cmd_arg}, {6'd17, 32'hA5A5_0001});
        host_clk_only = 0;

        // R4: wait flag set, open-ended transfer active
        host_wait_prev = 1; dp_active = 1; dp_byte_cnt = 0;
        host_cmd_idx = 6'd18; host_arg = 32'h0000_0200;
        exp_cmd(2'd0, 6'd18, 32'h0000_0200, 32'h40, 1, "R4 open-ended loads");
        pulse_start();
        tick(3);

        // R5: wait flag set, predefined transfer active -> deferred
        dp_byte_cnt = 16'd1024;
        host_cmd_idx = 6'd24; host_arg = 32'h0000_1000;
        seen = observed;
        pulse_start();
        tick(6);
        check(observed == seen, "R5 no load while predefined active", observed, seen);
        check(start_pending, "R5 request held", start_pending, 1);
        exp_cmd(2'd0, 6'd24, 32'h0000_1000, 32'h40, 1, "R5 load after transfer");
        dp_active = 0;
        tick(3);
        check(expq.size() == 0, "R5 deferred load issued", expq.size(), 0);

        // R4: wait flag set, no transfer at all
        host_cmd_idx = 6'd13; host_arg = 32'h1;
        exp_cmd(2'd0, 6'd13, 32'h1, 32'h40, 1, "R4 idle loads");
        pulse_start();
        tick(3);

        // R7: automatic stop
        host_tmo = 32'h77;
        exp_cmd(2'd1, 6'd12, 32'h0, 32'h77, 0, "R7 auto stop");
        dp_done = 1; tick(1); dp_done = 0;
        tick(3);

        // R8: interrupt response ignored when not waiting
        seen = observed;
        irq_send_req = 1; tick(1); irq_send_req = 0;
        tick(4);
        check(observed == seen, "R8 irq ignored without wait", observed, seen);
        irq_wait = 1;
        exp_cmd(2'd2, 6'd40, 32'h0, 32'h77, 0, "R8 irq response");
        irq_send_req = 1; tick(1); irq_send_req = 0;
        tick(3);

        // R10 / R9: all sources under busy, then released
        eng_busy = 1;
        host_cmd_idx = 6'd7; host_arg = 32'h0000_BEEF;
        seen = observed;
        host_start_set = 1; dp_done = 1; irq_send_req = 1;
        tick(1);
        host_start_set = 0; dp_done = 0; irq_send_req = 0;
        tick(5);
        check(observed == seen, "R10 busy blocks loads", observed, seen);
        check(start_pending, "R10 host request kept", start_pending, 1);
        exp_cmd(2'd1, 6'd12, 32'h0, 32'h77, 0, "R9 stop first");
        exp_cmd(2'd2, 6'd40, 32'h0, 32'h77, 0, "R9 irq second");
        exp_cmd(2'd0, 6'd7, 32'h0000_BEEF, 32'h77, 1, "R9 host last");
        eng_busy = 0;
        tick(6);
        check(expq.size() == 0, "R9 all grants seen", expq.size(), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule